// File: doc/BRIEF.md
# Paging Unit Control and Interrupt Register Block

This block is the software-facing side of an address translation unit. A host reaches it over a simple 32-bit register bus. The bus has a select, a write strobe, a byte address and write data. Reads are combinational. Through it the host loads the translation directory base, drives a small paging/stall state machine with command codes, reads back status and the faulting address, invalidates one translation-cache line or the whole cache, and handles a two-source interrupt with raw, clear, mask and masked views. A clock-gating control word is kept as plain storage.

The table walker reports page faults (virtual address plus access direction) and bus read errors. The block latches the first fault and holds translation off until software acknowledges it. It sends one-cycle invalidation pulses to the translation cache and raises an interrupt line while any enabled source is pending. A force-reset command returns every register to its reset value.

Top module: `pgu_ctrl_regs`

Register word map (byte offsets): 0x00 directory base, 0x04 status, 0x08 command, 0x0C fault address, 0x10 invalidate one, 0x14 raw interrupt, 0x18 interrupt clear, 0x1C interrupt mask, 0x20 masked interrupt, 0x24 gating control. Interrupt bit 0 is page fault and bit 1 is bus error. Status bits: 0 paging on, 1 fault active, 2 stall active, 3 walker idle, 4 replay buffer empty, 5 fault was a write, 31 stall not active; all other bits read 0.

## Requirements
- R1: A write to 0x00 stores bits 31:12 and the register reads the low 12 bits as zero (0xCAFEBABE reads 0xCAFEB000); the reset value is 0 and `dir_base` shows the stored value.
- R2: Command code 0 sets paging (status bit 0, `paging_on`) and code 1 clears it, with effect from the cycle after the write.
- R3: Command code 2 sets stall (status bit 2 set, bit 31 clear, `stall_on`) only when paging is already on, and otherwise has no effect; code 3 clears stall.
- R4: Command code 4 gives a one-cycle `tlb_inv_all` pulse in the cycle after the write. A write to 0x10 gives a one-cycle `tlb_inv_one` pulse in the cycle after the write, with `tlb_inv_va` equal to the written data.
- R5: A `walk_fault` while no fault is active sets status bit 1, raw interrupt bit 0, captures the address into 0x0C and the direction into status bit 5. A fault while one is active is ignored entirely.
- R6: Command code 5 clears status bits 1 and 5. `xlate_hold` is high exactly while stall or a fault is active.
- R7: A `walk_bus_err` sets raw interrupt bit 1, whatever the fault state.
- R8: Writing 0x18 clears the raw bits written as 1 and leaves the others. An event arriving in the same cycle wins over the clear.
- R9: 0x20 reads raw AND mask; 0x1C holds the 2-bit mask (reset 0); `irq` is high exactly while the masked value is nonzero.
- R10: Command code 6 returns every register and state to its reset value in the cycle after the write (directory base reads 0).
- R11: Writes to status, fault address, raw and masked registers, writes to unmapped or unaligned addresses, and command code 7 change nothing. Command, invalidate-one, clear and unmapped addresses read as 0, and every read with `bus_sel` low returns 0.
- R12: 0x24 stores all 32 written bits and reads them back; its reset value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| walk_fault | input | 1 | Page fault event from walker |
| walk_fault_va | input | 32 | Faulting virtual address |
| walk_fault_wr | input | 1 | Faulting access was a write |
| walk_bus_err | input | 1 | Bus read error event |
| walk_idle | input | 1 | Walker idle, shown in status bit 3 |
| replay_empty | input | 1 | Replay buffer empty, shown in status bit 4 |
| paging_on | output | 1 | Paging enabled |
| stall_on | output | 1 | Stall active |
| xlate_hold | output | 1 | Translation held (stall or fault) |
| tlb_inv_all | output | 1 | Invalidate whole cache pulse |
| tlb_inv_one | output | 1 | Invalidate one line pulse |
| tlb_inv_va | output | 32 | Address for single invalidation |
| dir_base | output | 32 | Directory base address |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences cover the cases that random stimulus rarely reaches: the masking of the directory base, stall requested with paging off, a second fault arriving while one is pending, a clear colliding with a bus error, and force reset after every register has been loaded. Random cycles then mix register writes, including ones to read-only and unmapped offsets, all eight command codes, and fault and bus-error events. A bench model predicts each read, the invalidation pulses and the state outputs, so a wrong priority between command, event and clear shows up as a mismatch. Walker idle and replay status inputs are varied randomly, so the status pass-through bits are separated from the stored bits.

// File: rtl/pgu_regs_pkg.sv
package pgu_regs_pkg;
    // word indices of the register map (byte offset / 4)
    localparam int W_DIR    = 0;
    localparam int W_STAT   = 1;
    localparam int W_CMD    = 2;
    localparam int W_FADDR  = 3;
    localparam int W_INV1   = 4;
    localparam int W_RAW    = 5;
    localparam int W_CLR    = 6;
    localparam int W_MASK   = 7;
    localparam int W_MSKD   = 8;
    localparam int W_GATE   = 9;

    localparam int DATA_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int INT_W      = 2;
    localparam int IRQ_FLT    = 0;
    localparam int IRQ_BERR   = 1;

    typedef enum logic [2:0] {
        CMD_PAGE_ON   = 3'd0,
        CMD_PAGE_OFF  = 3'd1,
        CMD_STALL_ON  = 3'd2,
        CMD_STALL_OFF = 3'd3,
        CMD_INV_ALL   = 3'd4,
        CMD_FLT_DONE  = 3'd5,
        CMD_FORCE_RST = 3'd6,
        CMD_NONE      = 3'd7
    } cmd_e;
endpackage

// File: rtl/pgu_cmd_seq.sv
module pgu_cmd_seq
    import pgu_regs_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_wr,
    input  logic [2:0]      cmd_code,
    input  logic            inv_one_wr,
    input  logic [VA_W-1:0] inv_one_va,
    input  logic            flt_evt,
    input  logic [VA_W-1:0] flt_va,
    input  logic            flt_wr,
    output logic            paging_o,
    output logic            stall_o,
    output logic            fault_o,
    output logic            fault_wr_o,
    output logic [VA_W-1:0] fault_va_o,
    output logic            inv_all_o,
    output logic            inv_one_o,
    output logic [VA_W-1:0] inv_va_o,
    output logic            force_rst_o,
    output logic            flt_take_o
);
    typedef struct packed {
        logic            paging;
        logic            stall;
        logic            fault;
        logic            fault_wr;
        logic [VA_W-1:0] fault_va;
        logic            inv_all;
        logic            inv_one;
        logic [VA_W-1:0] inv_va;
    } seq_t;

    seq_t st_d, st_q;
    logic force_rst, flt_take;

    always_comb begin
        st_d         = st_q;
        st_d.inv_all = 1'b0;
        st_d.inv_one = 1'b0;
        force_rst    = cmd_wr && (cmd_e'(cmd_code) == CMD_FORCE_RST);
        flt_take     = flt_evt && !st_q.fault && !force_rst;
        if (cmd_wr) begin
            case (cmd_e'(cmd_code))
                CMD_PAGE_ON:   st_d.paging = 1'b1;
                CMD_PAGE_OFF:  st_d.paging = 1'b0;
                CMD_STALL_ON:  if (st_q.paging) st_d.stall = 1'b1;
                CMD_STALL_OFF: st_d.stall = 1'b0;
                CMD_INV_ALL:   st_d.inv_all = 1'b1;
                CMD_FLT_DONE: begin
                    st_d.fault    = 1'b0;
                    st_d.fault_wr = 1'b0;
                end
                default: ;
            endcase
        end
        if (inv_one_wr) begin
            st_d.inv_one = 1'b1;
            st_d.inv_va  = inv_one_va;
        end
        if (flt_take) begin
            st_d.fault    = 1'b1;
            st_d.fault_wr = flt_wr;
            st_d.fault_va = flt_va;
        end
        if (force_rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign paging_o    = st_q.paging;
    assign stall_o     = st_q.stall;
    assign fault_o     = st_q.fault;
    assign fault_wr_o  = st_q.fault_wr;
    assign fault_va_o  = st_q.fault_va;
    assign inv_all_o   = st_q.inv_all;
    assign inv_one_o   = st_q.inv_one;
    assign inv_va_o    = st_q.inv_va;
    assign force_rst_o = force_rst;
    assign flt_take_o  = flt_take;

    assert_paging_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_code == 3'd0) |=> st_q.paging);
    assert_stall_needs_paging_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_code == 3'd2 && !st_q.paging && !st_q.stall) |=> !st_q.stall);
    assert_inv_all_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_code == 3'd4) |=> inv_all_o);
    assert_fault_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_evt && !fault_o && !(cmd_wr && cmd_code == 3'd6))
        |=> (fault_o && fault_va_o == $past(flt_va)));
    assert_fault_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !(cmd_wr && (cmd_code == 3'd5 || cmd_code == 3'd6)))
        |=> (fault_o && $stable(fault_va_o)));
    assert_fault_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_code == 3'd5 && fault_o) |=> !fault_o);
endmodule

// File: rtl/pgu_irq.sv
module pgu_irq
    import pgu_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_rst,
    input  logic             flt_set,
    input  logic             berr_set,
    input  logic             clr_wr,
    input  logic             mask_wr,
    input  logic [INT_W-1:0] wbits,
    output logic [INT_W-1:0] raw_o,
    output logic [INT_W-1:0] mask_o,
    output logic [INT_W-1:0] masked_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [INT_W-1:0] raw;
        logic [INT_W-1:0] mask;
    } irq_t;

    irq_t st_d, st_q;
    logic [INT_W-1:0] sets, clrs;

    always_comb begin
        st_d           = st_q;
        sets           = '0;
        sets[IRQ_FLT]  = flt_set;
        sets[IRQ_BERR] = berr_set;
        clrs           = clr_wr ? wbits : '0;
        st_d.raw       = (st_q.raw & ~clrs) | sets;
        if (mask_wr) st_d.mask = wbits;
        if (force_rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o    = st_q.raw;
    assign mask_o   = st_q.mask;
    assign masked_o = st_q.raw & st_q.mask;
    assign irq_o    = |masked_o;

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !flt_set && !berr_set) |=> ((raw_o & $past(wbits)) == '0));
    assert_bus_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_set && !force_rst) |=> raw_o[IRQ_BERR]);
    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && wbits == '0 && !force_rst) |=> !irq_o);
endmodule

// File: rtl/pgu_ctrl_regs.sv
module pgu_ctrl_regs
    import pgu_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              walk_fault,
    input  logic [31:0]       walk_fault_va,
    input  logic              walk_fault_wr,
    input  logic              walk_bus_err,
    input  logic              walk_idle,
    input  logic              replay_empty,
    output logic              paging_on,
    output logic              stall_on,
    output logic              xlate_hold,
    output logic              tlb_inv_all,
    output logic              tlb_inv_one,
    output logic [31:0]       tlb_inv_va,
    output logic [31:0]       dir_base,
    output logic              irq
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [DATA_W-1:0] DIR_KEEP = {{(DATA_W-PAGE_SHIFT){1'b1}}, {PAGE_SHIFT{1'b0}}};

    typedef struct packed {
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] gate;
    } top_t;

    top_t st_d, st_q;
    logic [WIDX_W-1:0] widx;
    logic aligned, wr_en;
    logic cmd_wr, inv_wr, clr_wr, mask_wr;
    logic force_rst, flt_take;
    logic fault_act, fault_wr;
    logic [DATA_W-1:0] fault_va;
    logic [INT_W-1:0] raw, mask, masked;
    logic [DATA_W-1:0] status;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_en   = bus_sel && bus_wr && aligned;
    assign cmd_wr  = wr_en && (widx == WIDX_W'(W_CMD));
    assign inv_wr  = wr_en && (widx == WIDX_W'(W_INV1));
    assign clr_wr  = wr_en && (widx == WIDX_W'(W_CLR));
    assign mask_wr = wr_en && (widx == WIDX_W'(W_MASK));

    pgu_cmd_seq #(.VA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_code   (bus_wdata[2:0]),
        .inv_one_wr (inv_wr),
        .inv_one_va (bus_wdata),
        .flt_evt    (walk_fault),
        .flt_va     (walk_fault_va),
        .flt_wr     (walk_fault_wr),
        .paging_o   (paging_on),
        .stall_o    (stall_on),
        .fault_o    (fault_act),
        .fault_wr_o (fault_wr),
        .fault_va_o (fault_va),
        .inv_all_o  (tlb_inv_all),
        .inv_one_o  (tlb_inv_one),
        .inv_va_o   (tlb_inv_va),
        .force_rst_o(force_rst),
        .flt_take_o (flt_take)
    );

    pgu_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .force_rst(force_rst),
        .flt_set  (flt_take),
        .berr_set (walk_bus_err),
        .clr_wr   (clr_wr),
        .mask_wr  (mask_wr),
        .wbits    (bus_wdata[INT_W-1:0]),
        .raw_o    (raw),
        .mask_o   (mask),
        .masked_o (masked),
        .irq_o    (irq)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en && widx == WIDX_W'(W_DIR))  st_d.dir  = bus_wdata & DIR_KEEP;
        if (wr_en && widx == WIDX_W'(W_GATE)) st_d.gate = bus_wdata;
        if (force_rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status     = '0;
        status[0]  = paging_on;
        status[1]  = fault_act;
        status[2]  = stall_on;
        status[3]  = walk_idle;
        status[4]  = replay_empty;
        status[5]  = fault_wr;
        status[31] = !stall_on;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && aligned) begin
            case (widx)
                WIDX_W'(W_DIR):   bus_rdata = st_q.dir;
                WIDX_W'(W_STAT):  bus_rdata = status;
                WIDX_W'(W_FADDR): bus_rdata = fault_va;
                WIDX_W'(W_RAW):   bus_rdata = DATA_W'(raw);
                WIDX_W'(W_MASK):  bus_rdata = DATA_W'(mask);
                WIDX_W'(W_MSKD):  bus_rdata = DATA_W'(masked);
                WIDX_W'(W_GATE):  bus_rdata = st_q.gate;
                default:          bus_rdata = '0;
            endcase
        end
    end

    assign dir_base   = st_q.dir;
    assign xlate_hold = stall_on || fault_act;

    assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == WIDX_W'(W_DIR))
        |=> (dir_base == {$past(bus_wdata[31:PAGE_SHIFT]), {PAGE_SHIFT{1'b0}}}));
    assert_force_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[2:0] == 3'd6)
        |=> (dir_base == '0 && !paging_on && !stall_on && !irq));
    assert_gate_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == WIDX_W'(W_GATE)) |=> (st_q.gate == $past(bus_wdata)));
    assert_status_ro_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == WIDX_W'(W_STAT) && !walk_fault)
        |=> ($stable(paging_on) && $stable(stall_on)));
endmodule

// File: tb/test_pgu_ctrl_regs.sv
`timescale 1ns/1ps
module test_pgu_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        walk_fault = 1'b0, walk_fault_wr = 1'b0, walk_bus_err = 1'b0;
    logic [31:0] walk_fault_va = '0;
    logic        walk_idle = 1'b1, replay_empty = 1'b1;
    logic        paging_on, stall_on, xlate_hold, tlb_inv_all, tlb_inv_one, irq;
    logic [31:0] tlb_inv_va, dir_base;

    always #5 clk = ~clk;

    pgu_ctrl_regs #(.ADDR_W(8)) i_pgu_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .walk_fault(walk_fault), .walk_fault_va(walk_fault_va),
        .walk_fault_wr(walk_fault_wr), .walk_bus_err(walk_bus_err),
        .walk_idle(walk_idle), .replay_empty(replay_empty),
        .paging_on(paging_on), .stall_on(stall_on), .xlate_hold(xlate_hold),
        .tlb_inv_all(tlb_inv_all), .tlb_inv_one(tlb_inv_one),
        .tlb_inv_va(tlb_inv_va), .dir_base(dir_base), .irq(irq)
    );

    int errors = 0, checks = 0;
    bit finished = 0;

    // bench model
    logic [31:0] m_dir, m_faddr, m_gate;
    logic        m_pag, m_stall, m_flt, m_fwr;
    logic [1:0]  m_raw, m_mask;
    logic        e_all, e_one;
    logic [31:0] e_va;
    logic        s_all, s_one;
    logic [31:0] s_va;

    task automatic model_reset();
        m_dir = '0; m_faddr = '0; m_gate = '0;
        m_pag = 0; m_stall = 0; m_flt = 0; m_fwr = 0;
        m_raw = '0; m_mask = '0;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[0] = m_pag; s[1] = m_flt; s[2] = m_stall; s[3] = walk_idle;
        s[4] = replay_empty; s[5] = m_fwr; s[31] = ~m_stall;
        return s;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a[1:0] != 2'b00) return '0;
        case (a[7:2])
            6'd0: return m_dir;
            6'd1: return exp_status();
            6'd3: return m_faddr;
            6'd5: return {30'd0, m_raw};
            6'd7: return {30'd0, m_mask};
            6'd8: return {30'd0, m_raw & m_mask};
            6'd9: return m_gate;
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        if (a[1:0] != 2'b00) return "R11";
        case (a[7:2])
            6'd0: return "R1";
            6'd1: return "R2";
            6'd3: return "R5";
            6'd5: return "R8";
            6'd7, 6'd8: return "R9";
            6'd9: return "R12";
            default: return "R11";
        endcase
    endfunction

    task automatic model_step(input logic w, input logic [7:0] a, input logic [31:0] d,
                              input logic f, input logic [31:0] fva, input logic fw, input logic be);
        logic old_flt = m_flt;
        logic [1:0] clr = '0;
        logic frst = 0, take;
        e_all = 0; e_one = 0; e_va = '0;
        if (w && a[1:0] == 2'b00) begin
            case (a[7:2])
                6'd0: m_dir = d & 32'hFFFF_F000;
                6'd2: case (d[2:0])
                    3'd0: m_pag = 1;
                    3'd1: m_pag = 0;
                    3'd2: if (m_pag) m_stall = 1;
                    3'd3: m_stall = 0;
                    3'd4: e_all = 1;
                    3'd5: begin m_flt = 0; m_fwr = 0; end
                    3'd6: frst = 1;
                    default: ;
                endcase
                6'd4: begin e_one = 1; e_va = d; end
                6'd6: clr = d[1:0];
                6'd7: m_mask = d[1:0];
                6'd9: m_gate = d;
                default: ;
            endcase
        end
        take = f && !old_flt;
        if (take) begin m_flt = 1; m_fwr = fw; m_faddr = fva; end
        m_raw = (m_raw & ~clr) | {be, take};
        if (frst) begin model_reset(); e_all = 0; end
    endtask

    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic f, input logic [31:0] fva, input logic fw, input logic be);
        @(negedge clk);
        bus_sel = w; bus_wr = w; bus_addr = a; bus_wdata = d;
        walk_fault = f; walk_fault_va = fva; walk_fault_wr = fw; walk_bus_err = be;
        @(negedge clk);
        s_all = tlb_inv_all; s_one = tlb_inv_one; s_va = tlb_inv_va;
        bus_sel = 0; bus_wr = 0; walk_fault = 0; walk_bus_err = 0;
        model_step(w, a, d, f, fva, fw, be);
        chk("R4", "inv_all pulse", {31'd0, s_all}, {31'd0, e_all});
        chk("R4", "inv_one pulse", {31'd0, s_one}, {31'd0, e_one});
        if (e_one) chk("R4", "inv_one address", s_va, e_va);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1, a, d, 0, '0, 0, 0);
    endtask

    task automatic rd_chk(input logic [7:0] a, input string req);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        chk(req, $sformatf("read %h", a), bus_rdata, exp_rd(a));
        bus_sel = 0;
    endtask

    task automatic out_chk();
        #1;
        chk("R2", "paging_on", {31'd0, paging_on}, {31'd0, m_pag});
        chk("R3", "stall_on", {31'd0, stall_on}, {31'd0, m_stall});
        chk("R6", "xlate_hold", {31'd0, xlate_hold}, {31'd0, m_stall | m_flt});
        chk("R9", "irq", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
        chk("R1", "dir_base", dir_base, m_dir);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state
        for (int i = 0; i < 11; i++) rd_chk(8'(i * 4), req_of(8'(i * 4)));
        out_chk();

        // R1 directory base masking
        wr(8'h00, 32'hCAFE_BABE);
        rd_chk(8'h00, "R1");
        chk("R1", "dir value", dir_base, 32'hCAFE_B000);

        // R3 stall without paging is ignored
        wr(8'h08, 32'd2); rd_chk(8'h04, "R3"); out_chk();
        // R2/R3 paging then stall
        wr(8'h08, 32'd0); rd_chk(8'h04, "R2");
        wr(8'h08, 32'd2); rd_chk(8'h04, "R3"); out_chk();
        wr(8'h08, 32'd3); rd_chk(8'h04, "R3"); out_chk();

        // R4 invalidations
        wr(8'h08, 32'd4);
        wr(8'h10, 32'h1234_5000);

        // R5 fault capture, second fault ignored, R6 done
        wr(8'h1C, 32'd3);
        cyc(0, 8'h00, '0, 1, 32'hDEAD_1000, 1, 0);
        rd_chk(8'h0C, "R5"); rd_chk(8'h04, "R5"); rd_chk(8'h14, "R5"); out_chk();
        cyc(0, 8'h00, '0, 1, 32'hBEEF_2000, 0, 0);
        rd_chk(8'h0C, "R5"); rd_chk(8'h04, "R5");
        wr(8'h08, 32'd5); rd_chk(8'h04, "R6"); out_chk();

        // R7 bus error, R8 clear colliding with bus error
        cyc(0, 8'h00, '0, 0, '0, 0, 1); rd_chk(8'h14, "R7");
        cyc(1, 8'h18, 32'd3, 0, '0, 0, 1); rd_chk(8'h14, "R8");
        wr(8'h18, 32'd1); rd_chk(8'h14, "R8");
        wr(8'h18, 32'd2); rd_chk(8'h14, "R8");

        // R9 mask and masked status
        cyc(0, 8'h00, '0, 0, '0, 0, 1);
        wr(8'h1C, 32'd1); rd_chk(8'h20, "R9"); out_chk();
        wr(8'h1C, 32'd2); rd_chk(8'h20, "R9"); out_chk();

        // R11 read-only and unmapped writes, code 7
        wr(8'h04, 32'hFFFF_FFFF); rd_chk(8'h04, "R11");
        wr(8'h0C, 32'h5555_5555); rd_chk(8'h0C, "R11");
        wr(8'h14, 32'h0); wr(8'h20, 32'h0); rd_chk(8'h14, "R11");
        wr(8'h01, 32'h1111_1111); rd_chk(8'h00, "R11");
        wr(8'h08, 32'd7); out_chk();

        // R12 gating storage
        wr(8'h24, 32'hA5A5_5A5A); rd_chk(8'h24, "R12");

        // R10 force reset after loading everything
        wr(8'h08, 32'd0); wr(8'h08, 32'd2);
        cyc(0, 8'h00, '0, 1, 32'h0000_7000, 0, 1);
        wr(8'h08, 32'd6);
        for (int i = 0; i < 11; i++) rd_chk(8'(i * 4), "R10");
        out_chk();

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op = $urandom % 10;
            logic [7:0] a = 8'(($urandom % 11) * 4);
            if ($urandom % 16 == 0) a = a | 8'(1 + $urandom % 3);
            walk_idle = 1'($urandom); replay_empty = 1'($urandom);
            case (op)
                0, 1, 2, 3: wr(a, $urandom);
                4, 5: wr(8'h08, 32'($urandom % 8));
                6: cyc(0, 8'h00, '0, 1, $urandom, 1'($urandom), 0);
                7: cyc(0, 8'h00, '0, 0, '0, 0, 1);
                8: cyc(0, 8'h00, '0, 1, $urandom, 1'($urandom), 1);
                default: cyc(1, 8'h18, 32'($urandom % 4), 0, '0, 0, 1'($urandom));
            endcase
            begin
                logic [7:0] ra = 8'(($urandom % 11) * 4);
                rd_chk(ra, req_of(ra));
            end
            out_chk();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule